// File: doc/BRIEF.md
# Receive FIFO Error Status Accumulator

This block holds received characters in a small first-in first-out store. Each entry carries a data byte and three error flags: parity, framing and break. Beside the store it keeps a sticky error status register that the host reads. Each character's flags are ORed into that register. A push that finds the store full is dropped and sets an overrun bit in the same register.

There are two points at which flags can be folded into the register. The default point is the head of the store: a character's flags show only once it is the next one to be popped. A one-cycle command pulse moves accumulation to push time, so a bad character shows as soon as it is written, although the register then no longer tells which stored character was at fault. Push-time mode is sticky. Only the chip reset or the receiver reset returns the block to head mode, and the receiver reset also empties the store and clears the register.

Top module: `rx_err_accum`

## Requirements
- R1: After chip reset (`rst_n` low) the store is empty (`empty`=1, `full`=0), `early_mode`=0 and `status`=0.
- R2: In head mode an entry's flags are ORed into `status` on the clock edge after the edge that made it the head. This covers a push into an empty store and a pop that exposes the next entry. Flags of entries behind the head do not show. Status bit encoding: bit0 parity, bit1 framing, bit2 break (the same positions as `push_err`), bit3 overrun.
- R3: In head mode each entry is folded exactly once. After `err_clr`, an entry that stays at the head does not set its flags again.
- R4: A one-cycle `early_cmd` pulse sets `early_mode`. From then on, the flags of an accepted push show in `status` right after that push's clock edge.
- R5: Once `early_mode` is set, `err_clr` and pops do not clear it. It is cleared only by `rst_n` or `rx_rst`. While it is set, entries reaching the head add nothing to `status`.
- R6: `status` bits are sticky and are cleared only by `err_clr`, `rx_rst` or `rst_n`. Flags folded in the same cycle as `err_clr` survive the clear.
- R7: The store holds 16 entries and pops them in push order. `pop_data`/`pop_err` show the head entry. `full` and `empty` track the fill level. A pop while empty is ignored.
- R8: A push while `full` is dropped, leaves the stored entries unchanged and sets `status` bit3 (overrun). This holds in both modes, and the dropped entry's flags are not folded.
- R9: A `rx_rst` pulse empties the store, clears `status` and returns to head mode. It takes precedence over a push or command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset, asynchronous |
| rx_rst | input | 1 | Synchronous receiver reset pulse |
| early_cmd | input | 1 | Command pulse selecting push-time accumulation |
| err_clr | input | 1 | Clears the status register |
| push | input | 1 | Write one character into the store |
| push_data | input | 8 | Character to store |
| push_err | input | 3 | Flags of the character: {break, framing, parity} |
| pop | input | 1 | Remove the head entry |
| pop_data | output | 8 | Head entry data |
| pop_err | output | 3 | Head entry flags |
| empty | output | 1 | Store is empty |
| full | output | 1 | Store holds 16 entries |
| early_mode | output | 1 | Push-time accumulation active |
| status | output | 4 | Sticky status: {overrun, break, framing, parity} |

## Verification
In push-time mode `status` and the overrun bit change one edge after the push. In head mode `status` changes one edge after the edge that made the entry the head, which is two edges after a push into an empty store. The fill flags and `early_mode` follow one edge after their stimulus, while `pop_data` and `pop_err` show the head without delay. The bench drives on the falling edge and samples at the next falling edge. Each head-mode check is placed either directly after the exposing edge, where the status must still be unchanged, or one cycle later, where the flags must have appeared, so a result one cycle early or late fails. Popped entries are compared against a queue filled by the push task.

// File: rtl/rx_err_accum.sv
module rx_err_accum #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int EW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_rst,
  input  logic          early_cmd,
  input  logic          err_clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic [EW-1:0] push_err,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [EW-1:0] pop_err,
  output logic          empty,
  output logic          full,
  output logic          early_mode,
  output logic [EW:0]   status
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW+EW-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             head_done;

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;
  wire ovf     = push && full;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign {pop_data, pop_err} = mem[rd_ptr];

  wire [EW-1:0] head_fold = (!early_mode && !empty && !head_done) ? pop_err : '0;
  wire [EW-1:0] push_fold = (early_mode && do_push) ? push_err : '0;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (do_push && !rx_rst) mem[wr_ptr] <= {push_data, push_err};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (rx_rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      head_done <= 1'b0;
    else if (rx_rst) head_done <= 1'b0;
    else             head_done <= do_pop ? 1'b0 : !empty;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         early_mode <= 1'b0;
    else if (rx_rst)    early_mode <= 1'b0;
    else if (early_cmd) early_mode <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      status <= '0;
    else if (rx_rst) status <= '0;
    else             status <= (err_clr ? '0 : status) | {ovf, head_fold | push_fold};

  assert_fill_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full) && (count <= CW'(DEPTH)));

  assert_mode_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    early_mode && !rx_rst |=> early_mode);

  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr && !rx_rst |=> ((status & $past(status)) == $past(status)));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !rx_rst |=> status[EW] && full);

  assert_early_fold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    early_mode && push && !full && !rx_rst
      |=> ((status[EW-1:0] & $past(push_err)) == $past(push_err)));

  assert_rx_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> empty && (status == '0) && !early_mode);
endmodule

// File: tb/sim_rx_err_accum.sv
`timescale 1ns/100ps
module sim_rx_err_accum;
  logic clk = 0, rst_n = 0, rx_rst = 0, early_cmd = 0, err_clr = 0, push = 0, pop = 0;
  logic [7:0] push_data = 0, pop_data;
  logic [2:0] push_err = 0, pop_err;
  logic empty, full, early_mode;
  logic [3:0] status;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [10:0] exp_q[$];

  always #2.5 clk = ~clk;

  rx_err_accum u0 (.clk, .rst_n, .rx_rst, .early_cmd, .err_clr, .push, .push_data,
    .push_err, .pop, .pop_data, .pop_err, .empty, .full, .early_mode, .status);

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_push(input logic [7:0] d, input logic [2:0] e);
    if (exp_q.size() < 16) exp_q.push_back({d, e});
    push = 1; push_data = d; push_err = e;
    @(negedge clk);
    push = 0;
  endtask

  task automatic do_pop();
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1;
    @(negedge clk);
    s = 0;
  endtask

  always @(negedge clk) begin
    #1;
    if (pop && !done) begin
      if (exp_q.size() > 0) begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk({pop_data, pop_err} == e, "R7 pop order", {5'd0, pop_data, pop_err}, {5'd0, e});
      end else
        chk(empty, "R7 pop on empty", 16'(empty), 16'd1);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    idle(3);
    chk(empty && !full && !early_mode && status == 0, "R1 reset state",
        {empty, full, early_mode, status}, 16'h0040);
    rst_n = 1;
    idle(1);

    // R2: head-mode timing, hidden errors behind the head
    do_push(8'h11, 3'b000);
    do_push(8'h22, 3'b001);
    idle(3);
    chk(status == 0, "R2 non-head error hidden", 16'(status), 0);
    do_pop();
    chk(status == 0, "R2 not yet folded after pop edge", 16'(status), 0);
    idle(1);
    chk(status == 4'b0001, "R2 fold one edge after becoming head", 16'(status), 1);

    // R3: folded once
    pulse(err_clr);
    chk(status == 0, "R6 clear", 16'(status), 0);
    idle(3);
    chk(status == 0, "R3 head not refolded", 16'(status), 0);
    do_pop();

    // R2: push into empty
    do_push(8'h33, 3'b010);
    chk(status == 0, "R2 push-into-empty not yet", 16'(status), 0);
    idle(1);
    chk(status == 4'b0010, "R2 push-into-empty folded", 16'(status), 2);
    do_pop();
    pulse(err_clr);

    // R6: clear in the fold cycle keeps new flags
    do_push(8'h34, 3'b100);
    pulse(err_clr);
    chk(status == 4'b0100, "R6 clear with same-cycle fold", 16'(status), 4);
    do_pop();
    pulse(err_clr);

    // R4/R5: early mode
    do_push(8'h44, 3'b001);
    idle(1);
    pulse(err_clr);
    pulse(early_cmd);
    chk(early_mode, "R4 early mode set", 16'(early_mode), 1);
    do_push(8'h55, 3'b010);
    chk(status == 4'b0010, "R4 fold at push edge", 16'(status), 2);
    do_push(8'h66, 3'b000);
    pulse(err_clr);
    do_pop();
    idle(2);
    chk(status == 0, "R5 no head fold in early mode", 16'(status), 0);
    do_pop();
    do_pop();
    chk(early_mode, "R5 early mode sticky", 16'(early_mode), 1);

    // R7/R8: fill and overrun in early mode
    for (int i = 0; i < 16; i++) do_push(8'(8'h80 + i), 3'b000);
    chk(full && !empty, "R7 full after 16", {14'd0, full, empty}, 16'h2);
    do_push(8'hEE, 3'b100);
    chk(status == 4'b1000, "R8 overrun early mode", 16'(status), 8);
    for (int i = 0; i < 16; i++) do_pop();
    chk(empty, "R7 empty after drain", 16'(empty), 1);
    do_pop();
    chk(empty && !full, "R7 pop on empty ignored", {14'd0, full, empty}, 16'h1);

    // R9: receiver reset
    do_push(8'h70, 3'b001);
    do_push(8'h71, 3'b010);
    pulse(rx_rst);
    exp_q.delete();
    chk(empty && status == 0 && !early_mode, "R9 rx reset",
        {empty, early_mode, status}, 16'h0020);
    do_push(8'h77, 3'b001);
    chk(status == 0, "R9 head mode back", 16'(status), 0);
    idle(1);
    chk(status == 4'b0001, "R9 head fold restored", 16'(status), 1);
    do_pop();
    pulse(err_clr);

    // R8: overrun in head mode
    for (int i = 0; i < 16; i++) do_push(8'(i), 3'b000);
    do_push(8'hEF, 3'b111);
    idle(1);
    chk(status == 4'b1000, "R8 overrun head mode", 16'(status), 8);
    for (int i = 0; i < 16; i++) do_pop();

    // R5: chip reset leaves early mode
    pulse(early_cmd);
    rst_n = 0;
    idle(1);
    rst_n = 1;
    idle(1);
    chk(!early_mode, "R5 chip reset leaves early", 16'(early_mode), 0);
    finish_run();
  end
endmodule